// File: doc/BRIEF.md
# Memory-Side Indirect Load Engine

This block sits beside a memory controller and serves loads on behalf of a processor. A request either asks for one plain read or for a chained pair of reads. In the chained case the first read fetches a pointer. The engine adds an optional signed offset to that pointer and uses the sum as the address of the second read. The requester sends one request and receives one response carrying the final data, so the pointer never travels back to the processor side.

Requests come in on a valid/ready channel. Both reads go out through a simple memory port that has valid/ready handshakes on its request and response sides, and either side may stall for any number of cycles. The engine works on one request at a time. Its controller moves through six states:

- ST_IDLE: ready for a request. Accepting one moves to ST_FIRST_READ.
- ST_FIRST_READ: presents the request address until the memory accepts it, then moves to ST_WAIT_FIRST.
- ST_WAIT_FIRST: waits for the first response.
  - An error moves to ST_RESPOND.
  - For a plain load, the response moves to ST_RESPOND.
  - For a chained request, the response moves to ST_SECOND_READ.
- ST_SECOND_READ: presents the computed address until it is accepted, then moves to ST_WAIT_SECOND.
- ST_WAIT_SECOND: the second response moves to ST_RESPOND.
- ST_RESPOND: holds the response until the requester takes it, then returns to ST_IDLE.

A synchronous reset sends the controller to ST_IDLE from any state.

Top module: `ptr_chase_engine`

## Requirements
- R1: While `rst` is high at a clock edge, the engine returns to idle. After that edge `req_ready`=1, `rsp_valid`=0 and `mem_req_valid`=0. An operation in flight is dropped and produces no response.
- R2: A request with `req_chain`=0 performs exactly one memory read, at `req_addr`. The response data equals that read's data.
- R3: A request with `req_chain`=1 performs exactly two memory reads. The first is at `req_addr`. The second is at the low ADDR_W bits of the first read's data, plus the offset when enabled. The response data equals the second read's data.
- R4: When `req_off_en`=1, `req_off` is sign-extended from OFF_W bits and added modulo 2^ADDR_W, and any carry out is discarded. When `req_off_en`=0, `req_off` has no effect and the pointer is used unchanged.
- R5: The second read is not requested until the first read's response has been accepted. After any read request is accepted, `mem_req_valid` is low in the next cycle.
- R6: `req_ready` is low from the cycle after a request is accepted until the response handshake completes.
- R7: `rsp_tag` equals the `req_tag` of the request being answered.
- R8: When `mem_rsp_err`=1 on the first read, no second read is issued. When it is 1 on either read, the response has `rsp_err`=1 and `rsp_data`=0. An error-free response has `rsp_err`=0.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, the memory request and its address stay unchanged. While `rsp_valid` is high and `rsp_ready` is low, the response fields stay unchanged. Any number of wait cycles is tolerated.
- R10: Each accepted request produces exactly one response. `rsp_valid` drops in the cycle after the response handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine can accept a request |
| req_chain | input | 1 | 1 = chained pair of reads, 0 = plain read |
| req_addr | input | ADDR_W | Address of the first (or only) read |
| req_off | input | OFF_W | Signed offset added to the pointer |
| req_off_en | input | 1 | 1 = apply the offset |
| req_tag | input | TAG_W | Requester's tag |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_data | output | DATA_W | Final data, zero on error |
| rsp_tag | output | TAG_W | Tag of the answered request |
| rsp_err | output | 1 | A memory read reported an error |
| mem_req_valid | output | 1 | Memory read request present |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | ADDR_W | Memory read address |
| mem_rsp_valid | input | 1 | Memory read data present |
| mem_rsp_ready | output | 1 | Engine accepts read data |
| mem_rsp_data | input | DATA_W | Memory read data |
| mem_rsp_err | input | 1 | Memory read failed |

## Verification
The assertions assume that the memory returns a response only for a read it has accepted and keeps at most one read outstanding. They also assume that the requester holds `rsp_ready` meaningful only while a response is offered. The bench memory model answers strictly after each granted read and inserts random stall cycles on both of its handshakes. The requester side adds random backpressure on `rsp_ready`. Reset is applied mid-operation only while the memory model is told to withhold its grant, so no stray memory response can reach the restarted engine.

// File: rtl/ptrc_pkg.sv
package ptrc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FIRST_READ,
        ST_WAIT_FIRST,
        ST_SECOND_READ,
        ST_WAIT_SECOND,
        ST_RESPOND
    } eng_state_e;

endpackage

// File: rtl/ptrc_addr_gen.sv
module ptrc_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int OFF_W  = 12
) (
    input  logic [DATA_W-1:0] ptr_data,
    input  logic [OFF_W-1:0]  off,
    input  logic              off_en,
    output logic [ADDR_W-1:0] next_addr
);
    localparam int EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] ptr;
    logic [ADDR_W-1:0] off_ext;

    // Pointer taken from the low bits of the read data, zero-extended if narrower.
    generate
        if (DATA_W >= ADDR_W) begin : g_trunc
            assign ptr = ptr_data[ADDR_W-1:0];
        end else begin : g_zext
            assign ptr = {{(ADDR_W-DATA_W){1'b0}}, ptr_data};
        end
    endgenerate

    generate
        if (EXT_W > 0) begin : g_sext
            assign off_ext = {{EXT_W{off[OFF_W-1]}}, off};
        end else begin : g_cut
            assign off_ext = off[ADDR_W-1:0];
        end
    endgenerate

    // Modulo 2^ADDR_W sum: carry out is dropped by the width of the result.
    assign next_addr = ptr + (off_en ? off_ext : '0);

endmodule

// File: rtl/ptrc_ctrl.sv
module ptrc_ctrl
    import ptrc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic chain_q,
    input  logic mem_req_ready,
    input  logic mem_rsp_valid,
    input  logic mem_rsp_err,
    input  logic rsp_ready,
    output logic req_ready,
    output logic mem_req_valid,
    output logic mem_rsp_ready,
    output logic rsp_valid,
    output logic accept,
    output logic rd_done,
    output logic first_phase
);
    eng_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:        if (req_valid) state_d = ST_FIRST_READ;
            ST_FIRST_READ:  if (mem_req_ready) state_d = ST_WAIT_FIRST;
            ST_WAIT_FIRST: begin
                if (mem_rsp_valid) begin
                    if (mem_rsp_err || !chain_q) state_d = ST_RESPOND;
                    else                         state_d = ST_SECOND_READ;
                end
            end
            ST_SECOND_READ: if (mem_req_ready) state_d = ST_WAIT_SECOND;
            ST_WAIT_SECOND: if (mem_rsp_valid) state_d = ST_RESPOND;
            ST_RESPOND:     if (rsp_ready) state_d = ST_IDLE;
            default:        state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready     = 1'b0;
        mem_req_valid = 1'b0;
        mem_rsp_ready = 1'b0;
        rsp_valid     = 1'b0;
        first_phase   = 1'b0;
        unique case (state_q)
            ST_IDLE:        req_ready = 1'b1;
            ST_FIRST_READ:  mem_req_valid = 1'b1;
            ST_WAIT_FIRST: begin
                mem_rsp_ready = 1'b1;
                first_phase   = 1'b1;
            end
            ST_SECOND_READ: mem_req_valid = 1'b1;
            ST_WAIT_SECOND: mem_rsp_ready = 1'b1;
            ST_RESPOND:     rsp_valid = 1'b1;
            default:        req_ready = 1'b0;
        endcase
        accept  = req_valid && req_ready;
        rd_done = mem_rsp_valid && mem_rsp_ready;
    end

    // R6: once a request is taken, no further request is accepted next cycle
    a_r6_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R5: an accepted read is followed by a wait, never a back-to-back read
    a_r5_wait_after_issue: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

    // R10: a completed response handshake is not repeated
    a_r10_single_response: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_ready) |=> !rsp_valid);

endmodule

// File: rtl/ptr_chase_engine.sv
module ptr_chase_engine #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int OFF_W  = 12,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_chain,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [OFF_W-1:0]  req_off,
    input  logic              req_off_en,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_data,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic              rsp_err,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    output logic              mem_rsp_ready,
    input  logic [DATA_W-1:0] mem_rsp_data,
    input  logic              mem_rsp_err
);
    logic              chain_q;
    logic              off_en_q;
    logic [OFF_W-1:0]  off_q;
    logic [TAG_W-1:0]  tag_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              err_q;
    logic              accept;
    logic              rd_done;
    logic              first_phase;
    logic [ADDR_W-1:0] chase_addr;

    ptrc_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .chain_q       (chain_q),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_err   (mem_rsp_err),
        .rsp_ready     (rsp_ready),
        .req_ready     (req_ready),
        .mem_req_valid (mem_req_valid),
        .mem_rsp_ready (mem_rsp_ready),
        .rsp_valid     (rsp_valid),
        .accept        (accept),
        .rd_done       (rd_done),
        .first_phase   (first_phase)
    );

    ptrc_addr_gen #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .OFF_W  (OFF_W)
    ) u_addr_gen (
        .ptr_data  (mem_rsp_data),
        .off       (off_q),
        .off_en    (off_en_q),
        .next_addr (chase_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q  <= 1'b0;
            off_en_q <= 1'b0;
            off_q    <= '0;
            tag_q    <= '0;
            addr_q   <= '0;
            data_q   <= '0;
            err_q    <= 1'b0;
        end else if (accept) begin
            chain_q  <= req_chain;
            off_en_q <= req_off_en;
            off_q    <= req_off;
            tag_q    <= req_tag;
            addr_q   <= req_addr;
            data_q   <= '0;
            err_q    <= 1'b0;
        end else if (rd_done) begin
            if (mem_rsp_err) begin
                data_q <= '0;
                err_q  <= 1'b1;
            end else if (first_phase && chain_q) begin
                addr_q <= chase_addr;
            end else begin
                data_q <= mem_rsp_data;
            end
        end
    end

    assign mem_req_addr = addr_q;
    assign rsp_data     = data_q;
    assign rsp_tag      = tag_q;
    assign rsp_err      = err_q;

    // R9: a stalled memory request keeps its address
    a_r9_mem_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R9: a stalled response keeps all its fields
    a_r9_rsp_hold: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=>
            (rsp_valid && $stable(rsp_data) && $stable(rsp_tag) && $stable(rsp_err)));

    // R8: an errored response never carries data
    a_r8_err_zero_data: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> (rsp_data == '0));

endmodule

// File: tb/ptr_chase_engine_bench.sv
module ptr_chase_engine_bench;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int OW = 12;
    localparam int TW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_chain = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [OW-1:0] req_off = '0;
    logic          req_off_en = 1'b0;
    logic [TW-1:0] req_tag = '0;
    logic          rsp_valid;
    logic          rsp_ready = 1'b0;
    logic [DW-1:0] rsp_data;
    logic [TW-1:0] rsp_tag;
    logic          rsp_err;
    logic          mem_req_valid;
    logic          mem_req_ready = 1'b0;
    logic [AW-1:0] mem_req_addr;
    logic          mem_rsp_valid = 1'b0;
    logic          mem_rsp_ready;
    logic [DW-1:0] mem_rsp_data = '0;
    logic          mem_rsp_err = 1'b0;

    int            n_checks = 0;
    int            n_fail = 0;
    logic          mem_hold = 1'b0;
    logic          inj_e1 = 1'b0;
    logic          inj_e2 = 1'b0;
    int            rd_count = 0;
    logic [AW-1:0] rd_addr [0:3];

    always #5 clk = ~clk;

    ptr_chase_engine u_ptr_chase_engine (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_chain(req_chain),
        .req_addr(req_addr), .req_off(req_off), .req_off_en(req_off_en), .req_tag(req_tag),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
        .rsp_tag(rsp_tag), .rsp_err(rsp_err),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
        .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err)
    );

    function automatic logic [DW-1:0] mem_fn(input logic [AW-1:0] a);
        return a ^ 32'hFFFF_FFF0;
    endfunction

    function automatic logic [AW-1:0] sext(input logic [OW-1:0] o);
        return {{(AW-OW){o[OW-1]}}, o};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Memory model: one read at a time, random stalls on both handshakes.
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req_valid && !mem_hold && !rst) begin
                logic [AW-1:0] a;
                logic          e;
                repeat ($urandom_range(0, 3)) @(negedge clk);
                mem_req_ready = 1'b1;
                a = mem_req_addr;
                if (rd_count < 4) rd_addr[rd_count] = a;
                e = (rd_count == 0) ? inj_e1 : inj_e2;
                rd_count++;
                @(negedge clk);
                mem_req_ready = 1'b0;
                repeat ($urandom_range(0, 3)) @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem_fn(a);
                mem_rsp_err   = e;
                while (!mem_rsp_ready) @(negedge clk);
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                mem_rsp_err   = 1'b0;
            end
        end
    end

    task automatic run_req(input bit chain, input logic [AW-1:0] addr, input logic [OW-1:0] off,
                           input bit off_en, input logic [TW-1:0] tag, input bit e1, input bit e2);
        logic [AW-1:0] a2;
        logic [DW-1:0] d1, exp_data;
        bit            exp_err;
        int            exp_rds;
        int            ready_seen = 0;
        int            guard = 0;
        logic [DW-1:0] got_data;
        logic [TW-1:0] got_tag;
        logic          got_err;

        inj_e1 = e1; inj_e2 = e2; rd_count = 0;
        @(negedge clk);
        req_valid = 1'b1; req_chain = chain; req_addr = addr;
        req_off = off; req_off_en = off_en; req_tag = tag;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_off = ~off;                // later changes must not matter
        forever begin
            rsp_ready = ($urandom_range(0, 2) != 0);
            if (req_ready) ready_seen++;
            if (rsp_valid && rsp_ready) break;
            guard++;
            if (guard > 400) break;
            @(negedge clk);
        end
        got_data = rsp_data; got_tag = rsp_tag; got_err = rsp_err;
        @(negedge clk);
        rsp_ready = 1'b0;
        check(guard <= 400, "R10 response arrives", guard, 400);
        check(!rsp_valid, "R10 response dropped after handshake", rsp_valid, 0);

        d1 = mem_fn(addr);
        a2 = d1[AW-1:0] + (off_en ? sext(off) : '0);
        if (e1)          begin exp_err = 1; exp_data = '0; exp_rds = 1; end
        else if (!chain) begin exp_err = 0; exp_data = d1; exp_rds = 1; end
        else if (e2)     begin exp_err = 1; exp_data = '0; exp_rds = 2; end
        else             begin exp_err = 0; exp_data = mem_fn(a2); exp_rds = 2; end

        check(got_tag == tag, "R7 tag", got_tag, tag);
        check(got_err == exp_err, "R8 error flag", got_err, exp_err);
        check(got_data == exp_data, chain ? "R3 chained data" : "R2 single data", got_data, exp_data);
        check(rd_count == exp_rds, e1 ? "R8 reads after error" : (chain ? "R3 read count" : "R2 read count"),
              rd_count, exp_rds);
        check(rd_addr[0] == addr, "R2 first read address", rd_addr[0], addr);
        if (exp_rds == 2)
            check(rd_addr[1] == a2, "R4 second read address", rd_addr[1], a2);
        check(ready_seen == 0, "R6 busy while in flight", ready_seen, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'h1D2C3B4A));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        check(rsp_valid == 1'b0, "R1 no response after reset", rsp_valid, 0);
        check(mem_req_valid == 1'b0, "R1 no memory read after reset", mem_req_valid, 0);

        // Directed cases
        run_req(0, 32'h0000_1230, 12'h000, 0, 4'h3, 0, 0);   // R2 plain read
        run_req(1, 32'h0000_4000, 12'h7AB, 0, 4'h5, 0, 0);   // R4 offset ignored when disabled
        run_req(1, 32'h0000_4000, 12'h010, 1, 4'h6, 0, 0);   // R4 positive offset
        run_req(1, 32'hFFFF_FFF2, 12'hFFB, 1, 4'h7, 0, 0);   // R4 pointer 2, offset -5 wraps
        run_req(1, 32'h0000_000F, 12'h001, 1, 4'h8, 0, 0);   // R4 pointer all ones +1 carry dropped
        run_req(1, 32'h1234_5678, 12'h800, 1, 4'h9, 0, 0);   // R4 most negative offset
        run_req(1, 32'h0000_2000, 12'h004, 1, 4'hA, 1, 0);   // R8 error on first read
        run_req(1, 32'h0000_2000, 12'h004, 1, 4'hB, 0, 1);   // R8 error on second read
        run_req(0, 32'h0000_3000, 12'h000, 0, 4'hC, 1, 0);   // R8 error on plain read

        // Constrained random mix, R3 R5 R9
        for (int i = 0; i < 60; i++) begin
            run_req($urandom_range(0, 1), $urandom, $urandom, $urandom_range(0, 1),
                    $urandom, ($urandom_range(0, 9) == 0), ($urandom_range(0, 9) == 0));
        end

        // R1: reset drops an operation in flight
        mem_hold = 1'b1;
        inj_e1 = 0; inj_e2 = 0;
        @(negedge clk);
        req_valid = 1'b1; req_chain = 1'b1; req_addr = 32'h55; req_tag = 4'hE;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(mem_req_valid == 1'b1, "R1 read pending before reset", mem_req_valid, 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        mem_hold = 1'b0;
        check(req_ready == 1'b1, "R1 idle after mid-flight reset", req_ready, 1);
        check(mem_req_valid == 1'b0, "R1 read dropped by reset", mem_req_valid, 0);
        begin
            int rsp_seen = 0;
            rsp_ready = 1'b1;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                if (rsp_valid) rsp_seen++;
            end
            rsp_ready = 1'b0;
            check(rsp_seen == 0, "R1 no response for dropped request", rsp_seen, 0);
        end
        finish_run();
    end

endmodule